// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block drives and samples a bank of general-purpose pins through a small word-addressed register window. Software sets each pin's output value and chooses whether the pin drives. Input pins are read back after a two-stage synchronizer. Each pin can raise an interrupt. A 3-bit trigger code per pin picks one of five conditions: a rising edge, a falling edge, either edge, a high level or a low level.

Each pin has an enable bit that gates detection. A detected event sets a sticky status bit, and software clears it by writing ones. A mask decides which status bits reach the single interrupt output. The mask is changed only through a write-ones-to-set port and a write-ones-to-clear port. A soft-reset control returns the configuration to its power-up values while it is held at 1.

The bus has no wait states. A write takes effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr`. Word offsets are: 0x00 enable, 0x04 status, 0x08 masked-status view, 0x0C status clear, 0x10 mask set, 0x14 mask clear, 0x18 output data, 0x1C input data, 0x20 direction, 0x24 trigger bank 0, 0x28 trigger bank 1, 0x38 pin-use select, 0x3C soft reset. Every other offset reads zero, and so do the clear and mask-clear offsets.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Writing the output-data word (0x18) sets `pin_out` to its low 12 bits. Writing the direction word (0x20) sets `pin_oe` to its low 12 bits, where 1 means drive. Both words read back with bits 31:12 zero.
- R2: The input-data word (0x1C) returns `pin_in` after two register stages. A change that is driven between clock edges is readable after the second edge and not after the first.
- R3: Trigger code 001 sets the pin's status on a 0-to-1 input, code 000 on a 1-to-0 input and code 100 on either change. Codes 101, 110 and 111 never set status. An edge-set status bit stays at 1 until it is cleared.
- R4: Pin n (n<8) takes its trigger code from bits [4n+2:4n] of word 0x24. Pin n (n>=8) takes it from bits [4(n-8)+2:4(n-8)] of word 0x28. Bit 3 of each nibble reads 0, and nibbles with no pin read 0.
- R5: A status bit sets only while the pin's enable bit (word 0x00) is 1. An edge that is driven between clock edges shows in status three clock edges later.
- R6: The mask resets to all ones and reads at 0x10. Writing 1s at 0x10 sets mask bits and writing 1s at 0x14 clears them. Zero bits in either write leave the mask unchanged.
- R7: `irq` is high exactly when some status bit is 1 and its mask bit is 0. Word 0x08 reads status AND NOT mask.
- R8: Code 011 (high level) and code 010 (low level) set status on every cycle while the level holds. A clear written during that cycle does not win, and the bit stays 1.
- R9: While the soft-reset word (0x3C bit 0) is 1, the configuration and status registers are held at their reset values and writes to them are ignored. These are enable, status, mask, output data, direction, both trigger banks and pin-use select. Writing 0 to 0x3C releases them.
- R10: Writing 1s at 0x0C clears the matching edge-set status bits, and zero bits leave status unchanged. The pin-use select word (0x38) stores its low 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the word being accessed |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 12 | Raw pin inputs |
| pin_out | output | 12 | Output data to the pads |
| pin_oe | output | 12 | Per-pin drive enable |
| irq | output | 1 | Combined interrupt |

## Verification
Four behaviours are checked on every cycle by properties:
- no status bit rises while its enable was low;
- a mask-set write leaves the written bits set;
- a mask-clear write leaves the written bits clear;
- a held soft reset forces enable, mask and direction to their reset values.

Other behaviours show only in the bench's scenarios. These are the latency of the synchronizer and of detection, which trigger code fires on which input change, and the packing of the trigger nibbles across the two banks. They also include a level trigger beating a simultaneous clear, and unused trigger codes staying silent.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS = 12,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam int PADW = 32 - NPINS;
  localparam logic [AW-1:0] A_EN   = AW'('h00);
  localparam logic [AW-1:0] A_STAT = AW'('h04);
  localparam logic [AW-1:0] A_DISP = AW'('h08);
  localparam logic [AW-1:0] A_CLR  = AW'('h0C);
  localparam logic [AW-1:0] A_MSET = AW'('h10);
  localparam logic [AW-1:0] A_MCLR = AW'('h14);
  localparam logic [AW-1:0] A_DOUT = AW'('h18);
  localparam logic [AW-1:0] A_DIN  = AW'('h1C);
  localparam logic [AW-1:0] A_DIR  = AW'('h20);
  localparam logic [AW-1:0] A_M0   = AW'('h24);
  localparam logic [AW-1:0] A_M1   = AW'('h28);
  localparam logic [AW-1:0] A_SEL  = AW'('h38);
  localparam logic [AW-1:0] A_SRST = AW'('h3C);
  localparam logic [NPINS-1:0] ONES = '1;

  logic [NPINS-1:0] en_q, stat_q, mask_q, dout_q, dir_q, sel_q;
  logic [NPINS-1:0] s1_q, s2_q, s3_q, hit;
  logic [2:0]       mode_q [NPINS];
  logic             srst_q;
  logic [31:0]      m0w, m1w;

  wire              cfg_wr = bus_wr && !srst_q;
  wire [NPINS-1:0]  wbits  = bus_wdata[NPINS-1:0];
  wire [NPINS-1:0]  clr    = (cfg_wr && bus_addr == A_CLR) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
    end else begin
      s1_q <= pin_in; s2_q <= s1_q; s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else if (bus_wr && bus_addr == A_SRST) srst_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; stat_q <= '0; mask_q <= ONES;
      dout_q <= '0; dir_q <= '0; sel_q <= '0;
    end else if (srst_q) begin
      en_q <= '0; stat_q <= '0; mask_q <= ONES;
      dout_q <= '0; dir_q <= '0; sel_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | hit;
      if (bus_wr) begin
        case (bus_addr)
          A_EN:    en_q   <= wbits;
          A_MSET:  mask_q <= mask_q | wbits;
          A_MCLR:  mask_q <= mask_q & ~wbits;
          A_DOUT:  dout_q <= wbits;
          A_DIR:   dir_q  <= wbits;
          A_SEL:   sel_q  <= wbits;
          default: ;
        endcase
      end
    end
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    localparam int K = (n < 8) ? n : n - 8;
    localparam logic [AW-1:0] RA = (n < 8) ? A_M0 : A_M1;
    logic trig;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q[n] <= 3'b000;
      else if (srst_q) mode_q[n] <= 3'b000;
      else if (cfg_wr && bus_addr == RA) mode_q[n] <= bus_wdata[4*K +: 3];
    end

    always_comb begin
      case (mode_q[n])
        3'b000:  trig = s3_q[n] & ~s2_q[n];
        3'b001:  trig = s2_q[n] & ~s3_q[n];
        3'b010:  trig = ~s2_q[n];
        3'b011:  trig = s2_q[n];
        3'b100:  trig = s2_q[n] ^ s3_q[n];
        default: trig = 1'b0;
      endcase
    end
    assign hit[n] = en_q[n] & trig;
  end

  for (genvar k = 0; k < 8; k++) begin : g_nib
    if (k < NPINS) begin : g_lo
      assign m0w[4*k +: 4] = {1'b0, mode_q[k]};
    end else begin : g_lo0
      assign m0w[4*k +: 4] = 4'h0;
    end
    if (k + 8 < NPINS) begin : g_hi
      assign m1w[4*k +: 4] = {1'b0, mode_q[k+8]};
    end else begin : g_hi0
      assign m1w[4*k +: 4] = 4'h0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_EN:    bus_rdata = {{PADW{1'b0}}, en_q};
      A_STAT:  bus_rdata = {{PADW{1'b0}}, stat_q};
      A_DISP:  bus_rdata = {{PADW{1'b0}}, stat_q & ~mask_q};
      A_MSET:  bus_rdata = {{PADW{1'b0}}, mask_q};
      A_DOUT:  bus_rdata = {{PADW{1'b0}}, dout_q};
      A_DIN:   bus_rdata = {{PADW{1'b0}}, s2_q};
      A_DIR:   bus_rdata = {{PADW{1'b0}}, dir_q};
      A_M0:    bus_rdata = m0w;
      A_M1:    bus_rdata = m1w;
      A_SEL:   bus_rdata = {{PADW{1'b0}}, sel_q};
      A_SRST:  bus_rdata = {31'b0, srst_q};
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign irq     = |(stat_q & ~mask_q);

  assert_stat_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q)) & ~$past(en_q)) == '0);

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MSET && !srst_q) |=>
      ((mask_q & $past(wbits)) == $past(wbits)));

  assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MCLR && !srst_q) |=>
      ((mask_q & $past(wbits)) == '0));

  assert_srst_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (en_q == '0 && mask_q == ONES && dir_q == '0 && stat_q == '0));
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  gpio_irq_ctrl #(.NPINS(12), .AW(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic push(input int sel, input logic [31:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    push(0, exp, tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.sel)
          0: act = bus_rdata;
          1: act = {31'b0, irq};
          2: act = {20'b0, pin_out};
          default: act = {20'b0, pin_oe};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin : driver
    idle(3);
    rst_n = 1'b1;
    idle(1);
    rd(6'h10, 32'h0000_0FFF, "R6 mask reset");
    rd(6'h00, 32'h0, "R5 enable reset");
    rd(6'h04, 32'h0, "R10 status reset");
    rd(6'h20, 32'h0, "R1 dir reset");
    push(1, 0, "R7 irq reset");
    push(3, 0, "R1 oe reset");

    wr(6'h18, 32'hFFFF_FA5A);
    rd(6'h18, 32'h0000_0A5A, "R1 dout readback");
    push(2, 32'h0A5A, "R1 pin_out");
    wr(6'h20, 32'h0000_00F0);
    push(3, 32'h00F0, "R1 pin_oe");
    rd(6'h20, 32'h0000_00F0, "R1 dir readback");

    pin_in = 12'h3C3;
    rd(6'h1C, 32'h0, "R2 before first edge");
    rd(6'h1C, 32'h0, "R2 after one edge");
    rd(6'h1C, 32'h0000_03C3, "R2 after two edges");
    pin_in = '0;
    idle(4);

    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h24, 32'h7777_7777, "R4 bank0 packing");
    wr(6'h28, 32'hFFFF_FFFF);
    rd(6'h28, 32'h0000_7777, "R4 bank1 packing");
    wr(6'h24, 32'h0);
    wr(6'h28, 32'h0);

    wr(6'h24, 32'h0000_0001);
    wr(6'h00, 32'h0000_0001);
    pin_in[0] = 1'b1;
    idle(2);
    rd(6'h04, 32'h0, "R5 latency not yet");
    rd(6'h04, 32'h1, "R3 rising sets status");
    push(1, 0, "R7 masked no irq");
    rd(6'h08, 32'h0, "R7 display masked");
    wr(6'h14, 32'h0000_0001);
    push(1, 1, "R7 unmasked irq");
    rd(6'h08, 32'h1, "R7 display unmasked");
    rd(6'h10, 32'h0000_0FFE, "R6 mask clear");
    wr(6'h0C, 32'h0000_0001);
    rd(6'h04, 32'h0, "R10 clear status");
    push(1, 0, "R7 irq after clear");
    pin_in[0] = 1'b0;
    idle(4);
    rd(6'h04, 32'h0, "R3 rising ignores fall");

    pin_in[4] = 1'b1; idle(4);
    pin_in[4] = 1'b0; idle(4);
    rd(6'h04, 32'h0, "R5 disabled pin no status");

    wr(6'h00, 32'h0000_0003);
    pin_in[1] = 1'b1; idle(4);
    rd(6'h04, 32'h0, "R3 falling ignores rise");
    pin_in[1] = 1'b0; idle(4);
    rd(6'h04, 32'h2, "R3 falling sets");
    wr(6'h0C, 32'h0000_0002);

    wr(6'h24, 32'h0000_0401);
    wr(6'h00, 32'h0000_0007);
    pin_in[2] = 1'b1; idle(4);
    rd(6'h04, 32'h4, "R3 both edges rise");
    wr(6'h0C, 32'h0000_0004);
    rd(6'h04, 32'h0, "R10 clear both");
    pin_in[2] = 1'b0; idle(4);
    rd(6'h04, 32'h4, "R3 both edges fall");
    wr(6'h0C, 32'h0000_0004);

    wr(6'h24, 32'h0000_3401);
    wr(6'h00, 32'h0000_000F);
    pin_in[3] = 1'b1; idle(4);
    rd(6'h04, 32'h8, "R8 level high sets");
    wr(6'h0C, 32'h0000_0008);
    rd(6'h04, 32'h8, "R8 set beats clear");
    pin_in[3] = 1'b0; idle(4);
    rd(6'h04, 32'h8, "R8 sticky after level drop");
    wr(6'h0C, 32'h0000_0008);
    rd(6'h04, 32'h0, "R10 clear after level drop");

    wr(6'h28, 32'h0000_0020);
    wr(6'h00, 32'h0000_020F);
    rd(6'h04, 32'h0, "R8 low level one cycle later");
    rd(6'h04, 32'h200, "R4 pin9 low level via bank1");
    rd(6'h08, 32'h0, "R7 pin9 masked");
    pin_in[9] = 1'b1; idle(4);
    wr(6'h0C, 32'h0000_0200);
    rd(6'h04, 32'h0, "R8 low level released");

    wr(6'h24, 32'h0050_3401);
    wr(6'h00, 32'h0000_022F);
    pin_in[5] = 1'b1; idle(4);
    pin_in[5] = 1'b0; idle(4);
    rd(6'h04, 32'h0, "R3 unused code silent");

    wr(6'h10, 32'h0);
    rd(6'h10, 32'h0000_0FFE, "R6 zero set no change");
    wr(6'h14, 32'h0);
    rd(6'h10, 32'h0000_0FFE, "R6 zero clear no change");
    wr(6'h10, 32'h0000_0001);
    rd(6'h10, 32'h0000_0FFF, "R6 mask set");

    wr(6'h38, 32'hFFFF_FFFF);
    rd(6'h38, 32'h0000_0FFF, "R10 pin-use select");

    wr(6'h3C, 32'h1);
    rd(6'h3C, 32'h1, "R9 soft reset reads 1");
    wr(6'h00, 32'h0000_0FFF);
    rd(6'h00, 32'h0, "R9 write ignored in reset");
    wr(6'h3C, 32'h0);
    rd(6'h00, 32'h0, "R9 enable reset");
    rd(6'h10, 32'h0000_0FFF, "R9 mask reset");
    rd(6'h18, 32'h0, "R9 dout reset");
    rd(6'h24, 32'h0, "R9 bank0 reset");
    rd(6'h28, 32'h0, "R9 bank1 reset");
    rd(6'h38, 32'h0, "R9 select reset");
    push(3, 0, "R9 oe reset");
    push(2, 0, "R9 pin_out reset");
    idle(3);
    done = 1'b1;
    report();
  end
endmodule